// File: doc/BRIEF.md
# Serial Audio Input Port

This block receives two-channel PCM audio over a three-wire link made of a frame clock, a bit clock and one serial data line. It delivers each stereo pair as two parallel words in the master-clock domain, with a single-cycle valid strobe. The block can generate both clocks from the master clock as the clock master. As a slave it can instead take the clocks from the attached source. The two roles share one data path.

Configuration inputs set the following while the port runs: the bit-clock edge that samples data, which frame-clock level carries the left channel, the sample resolution, left or right justification, and an optional one-slot delay before the first data bit. In slave mode all three wires pass through multi-flop synchronisers. Edges are detected after the synchronisers, so the bit clock may be asynchronous to the master clock and may pause between bursts.

Top module: `pcm3w_rx`

## Requirements
- R1: While rst_ni is low, valid_o, left_o, right_o, bclk_o and lrclk_o are all zero.
- R2: With cfg_master_i high, bclk_o toggles every MCLK_DIV_HALF master-clock cycles. lrclk_o changes only at a bit-clock inactive edge. Each lrclk_o level lasts SLOTS_PER_PHASE bit periods, which gives a 50% duty cycle.
- R3: With cfg_master_i low, bclk_o and lrclk_o stay zero, and bclk_i and lrclk_i time the port.
- R4: cfg_bclk_fall_i = 0 samples data on the rising bit-clock edge. cfg_bclk_fall_i = 1 samples on the falling edge.
- R5: The frame-clock phase whose level equals cfg_lr_inv_i carries the left sample. The other phase carries the right sample.
- R6: cfg_res_i selects the resolution N: code 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. Data arrives MSB first.
- R7: With cfg_rjust_i = 0, the sample is the first N bits of the phase. With cfg_rjust_i = 1, it is the last N bits before the next frame-clock transition.
- R8: With cfg_delay_i = 1 in left-justified mode, the first slot after a frame-clock transition is skipped and the MSB sits in the second slot.
- R9: Outputs are N-bit samples sign-extended to 24 bits.
- R10: valid_o is a one-cycle pulse raised after the frame-clock transition that ends a right phase. The pulse only occurs if the preceding left phase was seen in full since reset.
- R11: Pauses in the bit clock between slots do not change the received words.
- R12: The first active bit-clock edge after a frame-clock transition is slot 0 of the new phase. No earlier edge counts toward it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_master_i | input | 1 | 1: generate clocks, 0: take external clocks |
| cfg_bclk_fall_i | input | 1 | Active bit-clock edge: 0 rising, 1 falling |
| cfg_lr_inv_i | input | 1 | Frame-clock level that marks the left phase |
| cfg_res_i | input | 2 | Resolution code (16/18/20/24) |
| cfg_rjust_i | input | 1 | 1: right-justified, 0: left-justified |
| cfg_delay_i | input | 1 | One-slot delay before the MSB (left-justified) |
| bclk_i | input | 1 | External bit clock (slave) |
| lrclk_i | input | 1 | External frame clock (slave) |
| sdata_i | input | 1 | Serial data |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrclk_o | output | 1 | Generated frame clock (master) |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new pair |

## Verification
The bench builds the port with MCLK_DIV_HALF = 2 and SLOTS_PER_PHASE = 32, so a generated frame is 256 master-clock cycles. Many master-mode frames therefore fit in a short run, and the divider and frame-length checks compare against small exact numbers. SYNC_STAGES stays at 2. In slave mode the bench drives a 6-cycle bit period with inserted gaps. This exercises the asynchronous, gapped bit clock, both edge polarities and every resolution code. Each setting runs against words whose sign bits and justification make a wrong slot count visible.

// File: rtl/pcm3w_pkg.sv
package pcm3w_pkg;
   localparam int SAMPLE_W = 24;

   typedef enum logic [1:0] {
      RES_16 = 2'd0,
      RES_18 = 2'd1,
      RES_20 = 2'd2,
      RES_24 = 2'd3
   } res_e;

   function automatic int res_bits(res_e r);
      case (r)
         RES_16:  return 16;
         RES_18:  return 18;
         RES_20:  return 20;
         default: return 24;
      endcase
   endfunction

   // Keep the low N bits and copy bit N-1 into all higher positions.
   function automatic logic [SAMPLE_W-1:0] sign_fill(logic [SAMPLE_W-1:0] raw, res_e r);
      logic [SAMPLE_W-1:0] res;
      int n;
      n = res_bits(r);
      for (int i = 0; i < SAMPLE_W; i++)
         res[i] = (i < n) ? raw[i] : raw[n-1];
      return res;
   endfunction
endpackage

// File: rtl/pcm3w_clkgen.sv
module pcm3w_clkgen #(
   parameter int DIV_HALF = 4,
   parameter int SLOTS    = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic fall_i,
   output logic bclk_o,
   output logic lrclk_o
);
   localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic          tick;
   logic [SW-1:0] slot_q;
   logic          bclk_q, lr_q;

   if (DIV_HALF == 1) begin : g_nodiv
      assign tick = en_i;
   end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                          div_q <= '0;
         else if (!en_i)                       div_q <= '0;
         else if (div_q == DW'(DIV_HALF - 1))  div_q <= '0;
         else                                  div_q <= div_q + 1'b1;
      end
      assign tick = en_i && (div_q == DW'(DIV_HALF - 1));
   end

   // The frame clock moves only together with an inactive bit-clock edge.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_q <= 1'b0;
         lr_q   <= 1'b0;
         slot_q <= '0;
      end else if (!en_i) begin
         bclk_q <= 1'b0;
         lr_q   <= 1'b0;
         slot_q <= '0;
      end else if (tick) begin
         bclk_q <= ~bclk_q;
         if ((~bclk_q) == fall_i) begin
            if (slot_q == SW'(SLOTS - 1)) begin
               slot_q <= '0;
               lr_q   <= ~lr_q;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
         end
      end
   end

   assign bclk_o  = bclk_q;
   assign lrclk_o = lr_q;

   assert_lr_on_inactive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && $past(en_i) && $stable(fall_i) && !$stable(lrclk_o)) |-> (bclk_o == fall_i));
endmodule

// File: rtl/pcm3w_sync.sv
module pcm3w_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pcm3w_deser.sv
module pcm3w_deser
   import pcm3w_pkg::*;
#(
   parameter int MAX_SLOTS = 63
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                act_i,
   input  logic                lr_chg_i,
   input  logic                lr_lvl_i,
   input  logic                bit_i,
   input  logic                lr_inv_i,
   input  res_e                res_i,
   input  logic                rjust_i,
   input  logic                delay_i,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   localparam int CW = $clog2(MAX_SLOTS + 1);

   logic [CW-1:0]       cnt_q, slot;
   logic [SAMPLE_W-1:0] sh_q, base, word, left_hold_q;
   logic                frame_ok_q, have_left_q, take, now_left;
   int                  n, first;

   always_comb begin
      slot     = lr_chg_i ? '0 : cnt_q;
      base     = lr_chg_i ? '0 : sh_q;
      n        = res_bits(res_i);
      first    = int'(delay_i);
      take     = rjust_i || ((int'(slot) >= first) && (int'(slot) < first + n));
      word     = sign_fill(sh_q, res_i);
      now_left = (lr_lvl_i == lr_inv_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         sh_q        <= '0;
         left_hold_q <= '0;
         frame_ok_q  <= 1'b0;
         have_left_q <= 1'b0;
         left_o      <= '0;
         right_o     <= '0;
         valid_o     <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (lr_chg_i) begin
            frame_ok_q <= 1'b1;
            if (frame_ok_q) begin
               if (!now_left) begin
                  left_hold_q <= word;
                  have_left_q <= 1'b1;
               end else if (have_left_q) begin
                  left_o      <= left_hold_q;
                  right_o     <= word;
                  valid_o     <= 1'b1;
                  have_left_q <= 1'b0;
               end
            end
         end
         if (act_i)         cnt_q <= (slot == CW'(MAX_SLOTS)) ? slot : slot + 1'b1;
         else if (lr_chg_i) cnt_q <= '0;
         if (act_i && take) sh_q <= {base[SAMPLE_W-2:0], bit_i};
         else if (lr_chg_i) sh_q <= '0;
      end
   end

   assert_valid_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
   assert_valid_after_right_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> $past(lr_chg_i && (lr_lvl_i == lr_inv_i)));
   assert_sign_fill_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (sign_fill(right_o, $past(res_i)) == right_o));
   assert_slot_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lr_chg_i |=> (cnt_q == CW'($past(act_i))));
endmodule

// File: rtl/pcm3w_rx.sv
module pcm3w_rx
   import pcm3w_pkg::*;
#(
   parameter int MCLK_DIV_HALF   = 4,
   parameter int SLOTS_PER_PHASE = 32,
   parameter int SYNC_STAGES     = 2,
   parameter int MAX_SLOTS       = 63
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                cfg_master_i,
   input  logic                cfg_bclk_fall_i,
   input  logic                cfg_lr_inv_i,
   input  logic [1:0]          cfg_res_i,
   input  logic                cfg_rjust_i,
   input  logic                cfg_delay_i,
   input  logic                bclk_i,
   input  logic                lrclk_i,
   input  logic                sdata_i,
   output logic                bclk_o,
   output logic                lrclk_o,
   output logic [SAMPLE_W-1:0] left_o,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                valid_o
);
   if (MCLK_DIV_HALF < 1)                 begin : g_bad_div   $error("MCLK_DIV_HALF must be at least 1"); end
   if (SYNC_STAGES < 2)                   begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (SLOTS_PER_PHASE < SAMPLE_W + 1)    begin : g_bad_slots $error("SLOTS_PER_PHASE too small for 24-bit data"); end
   if (MAX_SLOTS < SLOTS_PER_PHASE)       begin : g_bad_max   $error("MAX_SLOTS below SLOTS_PER_PHASE"); end

   logic       gen_b, gen_lr;
   logic [2:0] raw, synced;
   logic       b_prev_q, lr_prev_q, act, lr_chg;

   pcm3w_clkgen #(.DIV_HALF(MCLK_DIV_HALF), .SLOTS(SLOTS_PER_PHASE)) i_clkgen (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cfg_master_i), .fall_i(cfg_bclk_fall_i),
      .bclk_o(gen_b), .lrclk_o(gen_lr));

   assign bclk_o  = gen_b;
   assign lrclk_o = gen_lr;

   // Both roles pass through the same synchroniser so data and clocks stay aligned.
   assign raw = cfg_master_i ? {gen_b, gen_lr, sdata_i} : {bclk_i, lrclk_i, sdata_i};

   pcm3w_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         b_prev_q  <= 1'b0;
         lr_prev_q <= 1'b0;
      end else begin
         b_prev_q  <= synced[2];
         lr_prev_q <= synced[1];
      end
   end

   assign act    = cfg_bclk_fall_i ? (b_prev_q & ~synced[2]) : (~b_prev_q & synced[2]);
   assign lr_chg = synced[1] ^ lr_prev_q;

   pcm3w_deser #(.MAX_SLOTS(MAX_SLOTS)) i_deser (
      .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .lr_chg_i(lr_chg), .lr_lvl_i(synced[1]),
      .bit_i(synced[0]), .lr_inv_i(cfg_lr_inv_i), .res_i(res_e'(cfg_res_i)),
      .rjust_i(cfg_rjust_i), .delay_i(cfg_delay_i),
      .left_o(left_o), .right_o(right_o), .valid_o(valid_o));

   assert_slave_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_master_i && $past(!cfg_master_i)) |-> (!bclk_o && !lrclk_o));
endmodule

// File: tb/test_pcm3w_rx.sv
module test_pcm3w_rx;
   localparam int DIV = 2;
   localparam int SL  = 32;
   localparam int H   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m = 1'b0, fall = 1'b0, inv = 1'b0, rj = 1'b0, dly = 1'b0;
   logic [1:0] res = 2'd3;
   logic bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
   logic bclk_o, lrclk_o, valid_o;
   logic [23:0] left_o, right_o;

   int checks = 0, errors = 0, ng = 0;
   bit done = 0;
   logic [23:0] wl [4], wr [4], got_l [8], got_r [8];

   always #2 clk = ~clk;

   pcm3w_rx #(.MCLK_DIV_HALF(DIV), .SLOTS_PER_PHASE(SL), .SYNC_STAGES(2), .MAX_SLOTS(63)) i_pcm3w_rx (
      .clk_i(clk), .rst_ni(rst_n), .cfg_master_i(m), .cfg_bclk_fall_i(fall), .cfg_lr_inv_i(inv),
      .cfg_res_i(res), .cfg_rjust_i(rj), .cfg_delay_i(dly), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
      .sdata_i(sdata_i), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .left_o(left_o), .right_o(right_o),
      .valid_o(valid_o));

   always @(negedge clk) if (rst_n && valid_o && ng < 8) begin
      got_l[ng] = left_o;
      got_r[ng] = right_o;
      ng++;
   end

   function automatic int nbits();
      case (res) 2'd0: return 16; 2'd1: return 18; 2'd2: return 20; default: return 24; endcase
   endfunction

   function automatic logic bitval(logic [23:0] w, int s);
      int n, d, idx;
      n = nbits();
      if (s >= SL || s < 0) return 1'b0;
      if (rj) begin
         idx = SL - 1 - s;
         return (idx < n) ? w[idx] : 1'b0;
      end
      d = s - int'(dly);
      return (d >= 0 && d < n) ? w[n-1-d] : 1'b0;
   endfunction

   function automatic logic [23:0] expv(logic [23:0] w);
      logic [23:0] r;
      int n;
      n = nbits();
      for (int i = 0; i < 24; i++) r[i] = (i < n) ? w[i] : w[n-1];
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; sdata_i = 1'b0; bclk_i = fall; lrclk_i = ~inv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      ng = 0;
   endtask

   task automatic compare(int nfr, string req);
      check(ng == nfr, "R10", "pair count", ng, nfr);
      for (int i = 0; i < nfr; i++) begin
         check(got_l[i] == expv(wl[i]), req, "left", got_l[i], expv(wl[i]));
         check(got_r[i] == expv(wr[i]), req, "right", got_r[i], expv(wr[i]));
      end
   endtask

   task automatic send_phase(logic [23:0] w, logic lvl, bit gap);
      for (int s = 0; s < SL; s++) begin
         bclk_i = fall;
         if (s == 0) lrclk_i = lvl;
         sdata_i = bitval(w, s);
         repeat (H) @(negedge clk);
         bclk_i = ~fall;
         repeat (H) @(negedge clk);
         if (gap && (s % 3 == 1)) repeat (9) @(negedge clk);
      end
   endtask

   task automatic run_slave(int nfr, bit gap, string req);
      m = 1'b0;
      do_reset();
      for (int f = 0; f < nfr; f++) begin
         send_phase(wl[f], inv, gap);
         send_phase(wr[f], ~inv, gap);
      end
      bclk_i = fall; lrclk_i = inv;
      repeat (12) @(negedge clk);
      compare(nfr, req);
      check(!bclk_o && !lrclk_o, "R3", "clock outputs in slave", {bclk_o, lrclk_o}, 0);
   endtask

   task automatic run_master(int nfr, string req);
      int fidx, slot, cyc, lastb, lastlr, half, phase;
      logic pb, plr;
      m = 1'b1;
      do_reset();
      fidx = -1; slot = 0; cyc = 0; lastb = 0; lastlr = 0; half = 0; phase = 0;
      pb = bclk_o; plr = lrclk_o;
      while (fidx < nfr) begin
         @(negedge clk);
         cyc++;
         if (bclk_o != pb) begin
            half = cyc - lastb;
            lastb = cyc;
            if (bclk_o == fall) begin
               if (lrclk_o != plr) begin
                  phase = cyc - lastlr;
                  lastlr = cyc;
                  slot = 0;
                  if (lrclk_o == inv) fidx++;
                  plr = lrclk_o;
               end else begin
                  slot++;
               end
               if (fidx >= 0 && fidx < nfr)
                  sdata_i = bitval((lrclk_o == inv) ? wl[fidx] : wr[fidx], slot);
               else
                  sdata_i = 1'b0;
            end
            pb = bclk_o;
         end
      end
      repeat (12) @(negedge clk);
      compare(nfr, req);
      check(half == DIV, "R2", "bit clock half period", half, DIV);
      check(phase == 2 * DIV * SL, "R2", "frame clock phase length", phase, 2 * DIV * SL);
   endtask

   task automatic t_reset();
      m = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (6) @(negedge clk);
      check(!valid_o && left_o == 0 && right_o == 0, "R1", "outputs in reset", {left_o[7:0], right_o[7:0], 7'd0, valid_o}, 0);
      check(!bclk_o && !lrclk_o, "R1", "clocks in reset", {bclk_o, lrclk_o}, 0);
   endtask

   task automatic t_i2s24();
      fall = 0; inv = 0; res = 2'd3; rj = 0; dly = 1;
      wl[0] = 24'h123456; wr[0] = 24'hABCDEF; wl[1] = 24'h800001; wr[1] = 24'h7FFFFF;
      run_slave(2, 0, "R4 R6 R8 R12");
   endtask

   task automatic t_fall_inv16();
      fall = 1; inv = 1; res = 2'd0; rj = 0; dly = 0;
      wl[0] = 24'h00C001; wr[0] = 24'h005A5A; wl[1] = 24'h7F8000; wr[1] = 24'h00FFFF;
      run_slave(2, 0, "R4 R5 R9");
   endtask

   task automatic t_rjust();
      fall = 0; inv = 0; rj = 1; dly = 0; res = 2'd1;
      wl[0] = 24'h02A5C3; wr[0] = 24'h01FFFF; wl[1] = 24'h000001; wr[1] = 24'h03C3C3;
      run_slave(2, 0, "R7 R6");
      res = 2'd2;
      wl[0] = 24'h0F0F0F; wr[0] = 24'h080000; wl[1] = 24'h07FFFF; wr[1] = 24'h0A0A0A;
      run_slave(2, 0, "R7 R9");
   endtask

   task automatic t_gap();
      fall = 0; inv = 0; res = 2'd3; rj = 0; dly = 0;
      wl[0] = 24'hC0FFEE; wr[0] = 24'h135790; wl[1] = 24'h2468AC; wr[1] = 24'hFEDCBA;
      run_slave(2, 1, "R11");
   endtask

   task automatic t_master();
      fall = 0; inv = 0; res = 2'd2; rj = 0; dly = 1;
      wl[0] = 24'h0ABCDE; wr[0] = 24'h012345; wl[1] = 24'h08FFFF; wr[1] = 24'h07AAAA;
      wl[2] = 24'h000010; wr[2] = 24'h0FFFF0;
      run_master(3, "R2 R8");
      fall = 1; inv = 1; res = 2'd3; rj = 1; dly = 0;
      wl[0] = 24'h951753; wr[0] = 24'h6A6A6A; wl[1] = 24'h000000; wr[1] = 24'hFFFFFF;
      run_master(2, "R2 R4 R5 R7");
   endtask

   initial begin
      t_reset();
      t_i2s24();
      t_fall_inv16();
      t_rjust();
      t_gap();
      t_master();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not complete actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule